// File: doc/BRIEF.md
# Bus Wake-Up Filter and Mode Controller

This block holds the digital mode and wake-up logic of a high-speed CAN transceiver. A mode-select pin chooses between an active mode and a low-power standby mode. In active mode the transmitter and the common-mode stabilisation output are enabled, and the receive pin shows the state of the full-speed receiver. In standby those enables are released. Only a low-power receiver is watched, and its dominant indication must pass a filter before it counts as a wake-up.

A valid wake-up drives the receive pin low for as long as the bus stays dominant. It also sets a sticky wake flag, and the mode does not change. Entry into standby takes effect at once. The return to active mode waits a programmable delay, and during that delay the outputs keep their standby behaviour. The parameter `UNCOND_WAKE` selects one of two wake-up variants. With the unconditioned variant, a bus that is already dominant at standby entry is reported after one filter time. With the conditioned variant, wake reporting is armed only after a recessive sample has been seen in standby. A node can therefore sleep on a bus held dominant by a fault.

The state machine has three states. ST_STBY is standby. ST_XFER is the standby-to-active delay. ST_NORM is active mode. The transitions are: ST_NORM to ST_STBY when the synchronised mode pin is high, ST_STBY to ST_XFER when it is low, ST_XFER to ST_STBY when it goes high again (an abort), and ST_XFER to ST_NORM after `XDLY_CYC` cycles in ST_XFER. Reset enters ST_STBY.

Top module: `wake_mode_ctrl`

## Requirements
- R1: After reset the block is in standby: receive pin 1, transmitter enable 0, split enable 0, active indication 0, wake flag 0. The conditioned variant also starts un-armed.
- R2: The mode pin and both dominant inputs pass through two flip-flops before any logic uses them. In active mode, a change on the bus-dominant input appears on the receive pin after the second rising edge.
- R3: In active mode the receive pin is the inverse of the synchronised bus-dominant input (1 means dominant), and transmitter enable, split enable and active indication are all 1. The low-power input has no effect on the receive pin.
- R4: In standby (ST_STBY and ST_XFER) transmitter enable, split enable and active indication are 0, and the bus-dominant input has no effect on the receive pin.
- R5: A low-power dominant run shorter than `FILT_CYC` consecutive synchronised samples leaves the receive pin at 1 and the wake flag at 0.
- R6: Once a run reaches `FILT_CYC` samples while armed, the receive pin is 0 for as long as the run lasts. It returns to 1 in the cycle after the first recessive sample.
- R7: The wake flag rises in the cycle after the first valid wake-up and stays set through standby and the transition delay. It is cleared on the edge that enters active mode.
- R8: A wake-up never changes the mode. The block remains in standby while the synchronised mode pin is high.
- R9: Active mode is entered only after `XDLY_CYC` cycles in ST_XFER with the mode pin low. If the mode pin rises during the delay, the block returns to ST_STBY and a later attempt restarts the full delay.
- R10: Standby is entered on the first edge at which the synchronised mode pin is high, with no delay.
- R11: With `UNCOND_WAKE`=1, if the low-power input is dominant at standby entry, the receive pin goes 1 in the first standby cycle and then 0 once the run reaches `FILT_CYC` samples.
- R12: With `UNCOND_WAKE`=0, reporting is armed only by a recessive low-power sample taken in standby. A dominant level present at entry never drives the receive pin low until the bus has gone recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_pin_i | input | 1 | Mode select, asynchronous; 1 = standby, 0 = active |
| bus_dom_i | input | 1 | Full-speed receiver output, asynchronous; 1 = bus dominant |
| lp_dom_i | input | 1 | Low-power receiver output, asynchronous; 1 = bus dominant |
| rxd_o | output | 1 | Receive pin level; 0 = dominant or wake-up |
| tx_en_o | output | 1 | Transmitter enable |
| split_en_o | output | 1 | Common-mode stabilisation output enable |
| norm_o | output | 1 | Active-mode indication |
| wake_o | output | 1 | Sticky wake-up flag |

## Verification
Most internal faults show on the receive pin within one filter time. A filter count that is off by one moves the falling edge of the receive pin by a cycle. A wrong arming decision makes the two variants look alike when standby is entered over a dominant bus. A wrong delay count moves the rise of the active indication and the enables, and a missed abort shows active mode while the mode pin is high. A reference model is compared with both variants on every cycle, so the first cycle in which a port differs is reported.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        ST_STBY = 2'd0,
        ST_XFER = 2'd1,
        ST_NORM = 2'd2
    } wk_state_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int unsigned W = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wk_filter.sv
module wk_filter #(
    parameter int unsigned FILT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dom_i,
    output logic ok_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (!en_i || !dom_i)  run_q <= '0;
        else if (run_q != LIMIT)   run_q <= run_q + 1'b1;
    end

    assign ok_o = (run_q == LIMIT);

    AST_FILT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> $past(en_i && dom_i)); // R5
endmodule

// File: rtl/wk_timer.sv
module wk_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/wake_mode_ctrl.sv
module wake_mode_ctrl
    import wk_pkg::*;
#(
    parameter int unsigned FILT_CYC    = 25,
    parameter int unsigned XDLY_CYC    = 75,
    parameter bit          UNCOND_WAKE = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_pin_i,
    input  logic bus_dom_i,
    input  logic lp_dom_i,
    output logic rxd_o,
    output logic tx_en_o,
    output logic split_en_o,
    output logic norm_o,
    output logic wake_o
);
    localparam int unsigned TW = $clog2(XDLY_CYC + 1);
    localparam logic [TW-1:0] XDLY_LAST = TW'(XDLY_CYC - 1);

    wk_state_e state_q, nxt;
    logic [2:0]    sync_q;
    logic          mode_s, bus_s, lp_s;
    logic          flt_ok;
    logic [TW-1:0] tmr_cnt;
    logic          armed_q, wake_q;

    // bit 0 is the mode pin, held high (standby) in reset
    wk_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({lp_dom_i, bus_dom_i, stby_pin_i}),
        .q_o   (sync_q)
    );
    assign mode_s = sync_q[0];
    assign bus_s  = sync_q[1];
    assign lp_s   = sync_q[2];

    wk_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (state_q != ST_NORM),
        .dom_i (lp_s),
        .ok_o  (flt_ok)
    );

    wk_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_q != ST_XFER),
        .cnt_o (tmr_cnt)
    );

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_NORM: if (mode_s) nxt = ST_STBY;
            ST_STBY: if (!mode_s) nxt = ST_XFER;
            ST_XFER: begin
                if (mode_s)                    nxt = ST_STBY;
                else if (tmr_cnt == XDLY_LAST) nxt = ST_NORM;
            end
            default: nxt = ST_STBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STBY;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= UNCOND_WAKE;
            wake_q  <= 1'b0;
        end else begin
            if (state_q == ST_NORM) begin
                if (mode_s) armed_q <= UNCOND_WAKE;
            end else if (!lp_s) begin
                armed_q <= 1'b1;
            end
            if (nxt == ST_NORM)
                wake_q <= 1'b0;
            else if (state_q != ST_NORM && armed_q && flt_ok)
                wake_q <= 1'b1;
        end
    end

    always_comb begin
        rxd_o      = 1'b1;
        tx_en_o    = 1'b0;
        split_en_o = 1'b0;
        norm_o     = 1'b0;
        unique case (state_q)
            ST_NORM: begin
                rxd_o      = ~bus_s;
                tx_en_o    = 1'b1;
                split_en_o = 1'b1;
                norm_o     = 1'b1;
            end
            ST_STBY, ST_XFER: rxd_o = ~(armed_q & flt_ok);
            default: rxd_o = 1'b1;
        endcase
    end
    assign wake_o = wake_q;

    AST_ENTER_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && $past(state_q) == ST_XFER) |-> $past(tmr_cnt) == XDLY_LAST); // R9
    AST_WAKE_FILT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> $past(flt_ok)); // R5
    AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM) |-> !wake_q); // R7
    AST_STAY_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NORM && mode_s) |=> (state_q == ST_STBY)); // R8
    AST_FAST_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && mode_s) |=> (state_q == ST_STBY)); // R10

    generate
        if (!UNCOND_WAKE) begin : g_cond
            AST_ARM_REC: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(armed_q) && armed_q) |-> !$past(lp_s)); // R12
        end
    endgenerate
endmodule

// File: tb/sim_wake_mode_ctrl.sv
module sim_wake_mode_ctrl;
    localparam int CLK_NS = 10;
    localparam int FILT   = 6;
    localparam int XDLY   = 12;
    localparam int WD_CYC = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby = 1'b1, bus = 1'b0, lp = 1'b0;
    logic r0, t0, s0, n0, w0;
    logic r1, t1, s1, n1, w1;
    int   vecs = 0, fails = 0;
    string cur_req = "R1";

    always #(CLK_NS/2) clk = ~clk;

    wake_mode_ctrl #(.FILT_CYC(FILT), .XDLY_CYC(XDLY), .UNCOND_WAKE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .stby_pin_i(stby), .bus_dom_i(bus), .lp_dom_i(lp),
        .rxd_o(r0), .tx_en_o(t0), .split_en_o(s0), .norm_o(n0), .wake_o(w0));
    wake_mode_ctrl #(.FILT_CYC(FILT), .XDLY_CYC(XDLY), .UNCOND_WAKE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .stby_pin_i(stby), .bus_dom_i(bus), .lp_dom_i(lp),
        .rxd_o(r1), .tx_en_o(t1), .split_en_o(s1), .norm_o(n1), .wake_o(w1));

    // reference model; mode: 0 standby, 1 delay, 2 active
    bit m_pipe[$], b_pipe[$], l_pipe[$];
    int md[2], run[2], tc[2];
    bit arm[2], wk[2];

    function automatic void mdl_reset();
        m_pipe = '{1'b1, 1'b1}; b_pipe = '{1'b0, 1'b0}; l_pipe = '{1'b0, 1'b0};
        for (int v = 0; v < 2; v++) begin
            md[v] = 0; run[v] = 0; tc[v] = 0; arm[v] = (v == 1); wk[v] = 1'b0;
        end
    endfunction

    initial mdl_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdl_reset();
        else begin
            bit ms, ls;
            ms = m_pipe[1]; ls = l_pipe[1];
            for (int v = 0; v < 2; v++) begin
                int ns;
                bit good;
                good = (md[v] != 2) && arm[v] && (run[v] >= FILT);
                ns = md[v];
                if (md[v] == 2)      begin if (ms) ns = 0; end
                else if (md[v] == 0) begin if (!ms) ns = 1; end
                else if (ms)         ns = 0;
                else if (tc[v] + 1 >= XDLY) ns = 2;
                wk[v] = (ns == 2) ? 1'b0 : (wk[v] | good);
                if (md[v] == 2) begin if (ms) arm[v] = (v == 1); end
                else if (!ls) arm[v] = 1'b1;
                run[v] = (md[v] == 2 || !ls) ? 0 : run[v] + 1;
                tc[v]  = (md[v] == 1 && ns == 1) ? tc[v] + 1 : 0;
                md[v]  = ns;
            end
            void'(m_pipe.pop_back()); m_pipe.push_front(stby);
            void'(b_pipe.pop_back()); b_pipe.push_front(bus);
            void'(l_pipe.pop_back()); l_pipe.push_front(lp);
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int v = 0; v < 2; v++) begin
                logic er, et, en;
                en = (md[v] == 2);
                er = en ? ~b_pipe[1] : ~(arm[v] && run[v] >= FILT);
                et = en;
                chk(cur_req, v ? "u1.rxd" : "u0.rxd",  v ? r1 : r0, er);
                chk(cur_req, v ? "u1.tx"  : "u0.tx",   v ? t1 : t0, et);
                chk(cur_req, v ? "u1.spl" : "u0.spl",  v ? s1 : s0, et);
                chk(cur_req, v ? "u1.nrm" : "u0.nrm",  v ? n1 : n0, en);
                chk(cur_req, v ? "u1.wake": "u0.wake", v ? w1 : w0, wk[v]);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        fails++;
        $display("FAIL %s watchdog actual=hung expected=done", cur_req);
        finish_run();
    end

    initial begin
        step(3);
        @(negedge clk); rst_n = 1'b1;
        at_neg();
        // R1 reset state
        chk("R1", "u0.rxd", r0, 1'b1); chk("R1", "u0.tx", t0, 1'b0);
        chk("R1", "u0.spl", s0, 1'b0); chk("R1", "u0.nrm", n0, 1'b0);
        chk("R1", "u1.wake", w1, 1'b0);
        step(4);

        cur_req = "R5";
        lp = 1'b1; step(FILT - 1); lp = 1'b0; step(6);
        at_neg();
        chk("R5", "u0.rxd short", r0, 1'b1); chk("R5", "u1.wake short", w1, 1'b0);

        cur_req = "R4";
        bus = 1'b1; step(5);
        at_neg();
        chk("R4", "u0.rxd bus ignored", r0, 1'b1); chk("R4", "u1.tx", t1, 1'b0);
        bus = 1'b0;

        cur_req = "R6";
        step(0);
        lp = 1'b1; step(FILT + 6);
        at_neg();
        chk("R6", "u0.rxd echo", r0, 1'b0); chk("R6", "u1.rxd echo", r1, 1'b0);
        lp = 1'b0; step(4);
        at_neg();
        chk("R6", "u0.rxd release", r0, 1'b1);
        chk("R7", "u0.wake set", w0, 1'b1);

        cur_req = "R8";
        step(20);
        at_neg();
        chk("R8", "u0.nrm stays", n0, 1'b0);

        cur_req = "R9";
        stby = 1'b0; step(3);
        lp = 1'b1; step(FILT + 2);
        at_neg();
        chk("R9", "u0.nrm in delay", n0, 1'b0); chk("R9", "u1.rxd in delay", r1, 1'b0);
        lp = 1'b0; step(6);
        at_neg();
        chk("R9", "u0.nrm after delay", n0, 1'b1); chk("R7", "u0.wake cleared", w0, 1'b0);

        cur_req = "R3";
        bus = 1'b1; step(4);
        at_neg();
        chk("R3", "u0.rxd dominant", r0, 1'b0);
        bus = 1'b0; lp = 1'b1; step(FILT + 3);
        at_neg();
        chk("R3", "u1.rxd lp ignored", r1, 1'b1);

        cur_req = "R2";
        bus = 1'b1; step(1);
        at_neg();
        chk("R2", "u0.rxd one edge", r0, 1'b1);
        step(1);
        at_neg();
        chk("R2", "u0.rxd two edges", r0, 1'b0);

        cur_req = "R10";
        stby = 1'b1; step(3);
        at_neg();
        chk("R10", "u0.nrm off", n0, 1'b0);
        chk("R11", "u1.rxd glitch", r1, 1'b1);
        cur_req = "R11";
        step(FILT);
        at_neg();
        chk("R11", "u1.rxd wake", r1, 1'b0);
        chk("R12", "u0.rxd not armed", r0, 1'b1);
        cur_req = "R12";
        bus = 1'b0; step(10);
        at_neg();
        chk("R12", "u0.rxd held", r0, 1'b1); chk("R12", "u0.wake clear", w0, 1'b0);
        lp = 1'b0; step(4);
        lp = 1'b1; step(FILT + 4);
        at_neg();
        chk("R12", "u0.rxd armed", r0, 1'b0);
        lp = 1'b0; step(4);

        cur_req = "R9";
        stby = 1'b0; step(6);
        stby = 1'b1; step(4);
        at_neg();
        chk("R9", "u0.nrm abort", n0, 1'b0);
        stby = 1'b0; step(XDLY);
        at_neg();
        chk("R9", "u1.nrm restart", n1, 1'b0);
        step(4);
        at_neg();
        chk("R9", "u1.nrm reached", n1, 1'b1);
        step(3);
        finish_run();
    end
endmodule